// File: doc/BRIEF.md
# Serial Register Port with Auto-Increment

This block is the serial front end of a small timekeeping peripheral. An external host frames each transaction with an active-high select line, sends one command byte, and then streams data bytes. The command byte carries a read flag, a fixed marker bit and a four-bit start register. Data bytes go to, or come from, a sixteen-entry file of 8-bit registers that sits outside this block. The register index steps forward after every byte.

The serial clock, select and data-in lines are not used as clocks. Each one passes through a two-stage synchroniser into the faster system clock, and the block finds the serial clock edges by comparing successive samples. Writes leave the block as one-cycle strobes that carry an address and data. Reads present an address and take the register contents back combinationally. A write to control register 0 whose value has bits 6, 4 and 3 all set also raises a soft-reset pulse for the rest of the peripheral.

Top module: `spi_regif_slave`

## Requirements
- R1: After the asynchronous reset, `wr_en`, `soft_rst` and `miso` are all low.
- R2: With a write command (bit 4 set, bit 7 clear), every complete data byte gives exactly one single-cycle `wr_en` pulse. The pulse carries the byte on `wr_data` and the current register index on `wr_addr`.
- R3: Bits 3:0 of the command byte give the first register index. Each further data byte in the same frame uses the next index.
- R4: The register index wraps from 15 to 0 inside a burst.
- R5: With a read command (bits 7 and 4 both set), `miso` returns the external register contents MSB first, starting at the start index and continuing at consecutive indices. `miso` changes after falling serial clock edges and is valid at each rising edge (mode 0). A read produces no `wr_en`.
- R6: A data byte written to register 0 whose bits 6, 4 and 3 are all set raises `soft_rst` for one cycle, in the same cycle as its `wr_en`. Any other address or value leaves `soft_rst` low.
- R7: A command byte with bit 4 clear is ignored. The frame produces no `wr_en`, and `miso` stays low until the select line drops.
- R8: While select is low, `miso` is low. A data byte cut short by select dropping is discarded, and the next frame begins with a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs | input | 1 | Active-high frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register index of the write |
| wr_data | output | 8 | Data of the write |
| rd_addr | output | 4 | Register index being read |
| rd_data | input | 8 | Contents of the register at `rd_addr` |
| soft_rst | output | 1 | One-cycle soft-reset pulse |

## Verification
The soft-reset pulse and the ordinary write strobe fall in the same system clock cycle. The reset pattern is an ordinary register write, so both outputs come from the same completed byte. The bench provokes this in two ways: directly, by writing the pattern to register 0, and by a burst that wraps through index 15 into index 0. It also writes near-miss cases: the pattern to register 1, and register 0 with only part of the pattern. The scoreboard judges each popped write by its expected soft-reset bit in that same cycle. A soft-reset pulse with no write in the same cycle is reported as a failure.

// File: rtl/spi_regif_slave.sv
module spi_regif_slave #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs,
  input  logic          mosi,
  output logic          miso,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          soft_rst
);
  localparam int BW = $clog2(DW);
  localparam int RD_BIT = 7;
  localparam int CMD_BIT = 4;
  localparam logic [DW-1:0] SRST_MASK = DW'(8'h58);

  logic [1:0] sck_sy, cs_sy, mosi_sy;
  logic sck_d;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] rx_sh;
  logic [DW-1:0] tx_sh;
  logic in_data, cmd_ok, rd_mode, miso_r;
  logic [AW-1:0] addr;

  wire sck_s = sck_sy[1];
  wire cs_s = cs_sy[1];
  wire mosi_s = mosi_sy[1];
  wire sck_rise = cs_s & sck_s & ~sck_d;
  wire sck_fall = cs_s & ~sck_s & sck_d;
  wire [DW-1:0] rx_byte = {rx_sh, mosi_s};
  wire byte_done = sck_rise && (bit_cnt == BW'(DW-1));
  wire rd_active = in_data & cmd_ok & rd_mode;

  assign miso = miso_r;
  assign rd_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0; cs_sy <= '0; mosi_sy <= '0; sck_d <= 1'b0;
      bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0;
      in_data <= 1'b0; cmd_ok <= 1'b0; rd_mode <= 1'b0; miso_r <= 1'b0;
      addr <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; soft_rst <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck};
      cs_sy <= {cs_sy[0], cs};
      mosi_sy <= {mosi_sy[0], mosi};
      sck_d <= sck_s;
      wr_en <= 1'b0;
      soft_rst <= 1'b0;
      if (!cs_s) begin
        bit_cnt <= '0;
        in_data <= 1'b0;
        cmd_ok <= 1'b0;
        rd_mode <= 1'b0;
        miso_r <= 1'b0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sh <= rx_byte[DW-2:0];
        end
        if (byte_done) begin
          if (!in_data) begin
            in_data <= 1'b1;
            cmd_ok <= rx_byte[CMD_BIT];
            rd_mode <= rx_byte[RD_BIT];
            addr <= rx_byte[AW-1:0];
          end else if (cmd_ok && !rd_mode) begin
            wr_en <= 1'b1;
            wr_addr <= addr;
            wr_data <= rx_byte;
            soft_rst <= (addr == '0) && ((rx_byte & SRST_MASK) == SRST_MASK);
            addr <= addr + 1'b1;
          end
        end
        if (sck_fall && rd_active) begin
          if (bit_cnt == '0) begin
            miso_r <= rd_data[DW-1];
            tx_sh <= {rd_data[DW-2:0], 1'b0};
            addr <= addr + 1'b1;
          end else begin
            miso_r <= tx_sh[DW-1];
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assert_wr_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(cs_s));
  assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  assert_srst_with_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (wr_en && wr_addr == '0 && wr_data[6] && wr_data[4] && wr_data[3]));
  assert_miso_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !miso);
  assert_ignored_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !cmd_ok) |-> (!wr_en && !miso));
  assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !wr_en);
endmodule

// File: tb/spi_regif_slave_tb.sv
module spi_regif_slave_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, wr_en, soft_rst;
  logic [3:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] regs [16];
  logic [7:0] exp_mem [16];

  typedef struct packed { logic [3:0] a; logic [7:0] d; logic s; } wr_t;
  wr_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rd_data = regs[rd_addr];

  spi_regif_slave dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs(cs), .mosi(mosi), .miso(miso),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .soft_rst(soft_rst)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && soft_rst && !wr_en)
      chk(0, "R6", "soft reset without write", 1, 0);
    if (rst_n && wr_en) begin
      if (q.size() == 0) begin
        chk(0, "R7", "unexpected write addr", int'(wr_addr), 0);
      end else begin
        wr_t e;
        e = q.pop_front();
        chk(wr_addr == e.a, "R3", "write address", int'(wr_addr), int'(e.a));
        chk(wr_data == e.d, "R2", "write data", int'(wr_data), int'(e.d));
        chk(soft_rst == e.s, "R6", "soft reset in write cycle", int'(soft_rst), int'(e.s));
      end
      regs[wr_addr] = wr_data;
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame_open();
    cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (HALF) @(negedge clk);
    cs = 1'b0;
    repeat (8) @(negedge clk);
    chk(miso == 1'b0, "R8", "miso idle after frame", int'(miso), 0);
  endtask

  task automatic wr_burst(input logic [3:0] start, input int n, input logic [7:0] base);
    logic [7:0] rx;
    frame_open();
    xfer({4'h1, start}, 8, rx);
    for (int k = 0; k < n; k++) begin
      logic [3:0] a;
      logic [7:0] d;
      wr_t e;
      a = start + 4'(k);
      d = base + 8'(k);
      e.a = a; e.d = d;
      e.s = (a == 4'h0) && ((d & 8'h58) == 8'h58);
      q.push_back(e);
      exp_mem[a] = d;
      xfer(d, 8, rx);
    end
    frame_close();
  endtask

  task automatic rd_burst(input logic [3:0] start, input int n, input string req);
    logic [7:0] rx;
    frame_open();
    xfer({4'h9, start}, 8, rx);
    for (int k = 0; k < n; k++) begin
      logic [3:0] a;
      a = start + 4'(k);
      xfer(8'hA5, 8, rx);
      chk(rx == exp_mem[a], req, "read data", int'(rx), int'(exp_mem[a]));
    end
    frame_close();
  endtask

  task automatic ignored_frame(input logic [7:0] cmd);
    logic [7:0] rx;
    frame_open();
    xfer(cmd, 8, rx);
    for (int k = 0; k < 2; k++) begin
      xfer(8'hFF, 8, rx);
      chk(rx == 8'h00, "R7", "miso on ignored command", int'(rx), 0);
    end
    frame_close();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 16; i++) begin regs[i] = 8'h00; exp_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
    chk(soft_rst == 1'b0, "R1", "soft_rst in reset", int'(soft_rst), 0);
    chk(miso == 1'b0, "R1", "miso in reset", int'(miso), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    wr_burst(4'h3, 1, 8'h6C);            // R2 single write
    rd_burst(4'h3, 1, "R5");
    wr_burst(4'h5, 16, 8'h20);           // R3 R4 burst through all indices with wrap
    rd_burst(4'h0, 16, "R3");
    rd_burst(4'hE, 4, "R4");             // read wrap 15 -> 0
    wr_burst(4'h0, 1, 8'h58);            // R6 exact pattern
    wr_burst(4'h1, 1, 8'h58);            // R6 wrong address
    wr_burst(4'h0, 1, 8'h50);            // R6 partial pattern
    wr_burst(4'h0, 1, 8'hFF);            // R6 superset of pattern
    wr_burst(4'hF, 2, 8'hD9);            // R6 reached through wrap (0xDA at 0)
    ignored_frame(8'h07);                // R7 write without marker
    ignored_frame(8'h82);                // R7 read without marker
    rd_burst(4'h0, 4, "R7");

    frame_open();                        // R8 cut-short byte is dropped
    xfer(8'h18, 8, rx);
    q.push_back('{a: 4'h8, d: 8'hA1, s: 1'b0});
    exp_mem[8] = 8'hA1;
    xfer(8'hA1, 8, rx);
    xfer(8'h3C, 3, rx);
    frame_close();
    rd_burst(4'h8, 2, "R8");
    rd_burst(4'h0, 1, "R5");

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2", "pending expected writes", q.size(), 0);
    finish_up();
  end
endmodule